// File: doc/BRIEF.md
# Victim Buffer for a Primary Cache Miss Path

This block is a small, fully associative store that sits beside a primary cache and catches the blocks that the cache throws out. Every block the cache evicts is written in together with its full block address, its data and a flag that says whether it was modified. The stored blocks are not tied to any cache set. They act as a handful of extra ways that every set can use.

When the primary cache misses, it probes the buffer with the missing block address. Every stored address is compared at the same time. The resulting one-hot match vector selects the block, and the block goes back to the cache one cycle later, together with its modified flag. A hit also removes the entry, so a block never sits in the cache and in the buffer at once.

Blocks leave the buffer in arrival order. When an insert finds every entry in use, the oldest entry is pushed out. If that entry was modified, it is handed to the next memory level on the eviction output. A clean entry that is pushed out is simply dropped.

Top module: `victim_buffer`

## Requirements
- R1: After reset the buffer holds nothing. Every probe misses, and neither `rsp_hit` nor `ev_valid` is asserted.
- R2: A probe (`prb_valid` high) is answered on the next clock. On a hit, `rsp_hit`=1, `rsp_data` carries the stored block and `rsp_dirty` its modified flag. On a miss, `rsp_hit`=0. A hit needs an exact match on all ADDR_W bits of the block address.
- R3: A probe hit removes the matching entry. A second probe of the same address misses.
- R4: While fewer than ENTRIES blocks are held, an insert stores the block and produces no eviction. Occupancy rises by one per insert and falls by one per probe hit.
- R5: An insert that finds all ENTRIES slots in use, with no probe hit in the same cycle, displaces the oldest remaining block in insertion order. If that block's modified flag is 1, `ev_valid` pulses for one cycle on the following clock, with `ev_addr` and `ev_data` holding that block.
- R6: A displaced block whose modified flag is 0 produces no `ev_valid` pulse, and a later probe of its address misses.
- R7: When a probe and an insert happen in the same cycle, the probe sees the contents from before the insert. A probe of the address being inserted misses. When the probe hits, the insert takes the freed space and nothing is displaced, even in a full buffer.
- R8: Removing a block from the middle of the arrival order keeps the relative order of the remaining blocks. Later displacements skip the removed block.
- R9: A probe address matches at most one entry, provided a block is inserted again only after it has left the buffer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ins_valid | input | 1 | Insert an evicted block this cycle |
| ins_addr | input | ADDR_W | Block address of the inserted block |
| ins_data | input | DATA_W | Data of the inserted block |
| ins_dirty | input | 1 | Modified flag of the inserted block |
| prb_valid | input | 1 | Probe the buffer this cycle |
| prb_addr | input | ADDR_W | Block address being probed |
| rsp_hit | output | 1 | Probe of the previous cycle hit |
| rsp_data | output | DATA_W | Block returned on a hit |
| rsp_dirty | output | 1 | Modified flag of the returned block |
| ev_valid | output | 1 | A modified block was displaced on the previous insert |
| ev_addr | output | ADDR_W | Address of the displaced block |
| ev_data | output | DATA_W | Data of the displaced block |

## Verification
The hardest state to reach from the ports is a full buffer in which one probe hit and one insert arrive in the same cycle. In that state the freed slot has to absorb the insert, so the modified block at the head must not be pushed out. A close second is a displacement that follows a removal from the middle of the arrival order.

The bench builds both states on purpose. It fills the buffer to capacity with a known arrival order and a mix of modified flags, and it keeps its own queue model. It then issues the paired probe and insert, and afterwards a further insert that must push out the surviving head.

A long sweep over a small address space mixes probes, inserts and paired cycles. This drives the buffer through many fill, drain and rollover sequences.

// File: rtl/vbuf_pkg.sv
package vbuf_pkg;

    localparam int unsigned VB_ENTRIES_DEF = 8;
    localparam int unsigned VB_ADDR_W_DEF  = 26;
    localparam int unsigned VB_DATA_W_DEF  = 64;

    // How an insert lands in the slot array this cycle
    typedef enum logic [1:0] {
        FILL_NONE   = 2'd0,
        FILL_APPEND = 2'd1,
        FILL_ROLL   = 2'd2
    } fill_mode_e;

    function automatic fill_mode_e pick_fill(input logic ins, input logic room);
        if (!ins)
            return FILL_NONE;
        else if (room)
            return FILL_APPEND;
        else
            return FILL_ROLL;
    endfunction

endpackage

// File: rtl/vbuf_match.sv
module vbuf_match #(
    parameter int unsigned ENTRIES = 8,
    parameter int unsigned ADDR_W  = 26,
    parameter int unsigned DATA_W  = 64,
    parameter int unsigned IDX_W   = 3
) (
    input  logic                             prb_valid,
    input  logic [ADDR_W-1:0]                prb_addr,
    input  logic [ENTRIES-1:0]               slot_valid,
    input  logic [ENTRIES-1:0][ADDR_W-1:0]   slot_addr,
    input  logic [ENTRIES-1:0][DATA_W-1:0]   slot_data,
    input  logic [ENTRIES-1:0]               slot_dirty,
    output logic [ENTRIES-1:0]               hit_vec,
    output logic                             hit_any,
    output logic [IDX_W-1:0]                 hit_idx,
    output logic [DATA_W-1:0]                hit_data,
    output logic                             hit_dirty
);

    // One comparator per slot, all in parallel
    for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
        assign hit_vec[i] = prb_valid & slot_valid[i] & (slot_addr[i] == prb_addr);
    end

    assign hit_any = |hit_vec;

    // AND-OR select driven by the one-hot match vector
    always_comb begin
        hit_data  = '0;
        hit_dirty = 1'b0;
        hit_idx   = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (hit_vec[i]) begin
                hit_data  = hit_data | slot_data[i];
                hit_dirty = hit_dirty | slot_dirty[i];
                hit_idx   = hit_idx | IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/vbuf_store.sv
module vbuf_store
    import vbuf_pkg::*;
#(
    parameter int unsigned ENTRIES = 8,
    parameter int unsigned ADDR_W  = 26,
    parameter int unsigned DATA_W  = 64,
    parameter int unsigned IDX_W   = 3,
    parameter int unsigned CNT_W   = 4
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             rm_en,
    input  logic [IDX_W-1:0]                 rm_idx,
    input  fill_mode_e                       mode,
    input  logic [ADDR_W-1:0]                new_addr,
    input  logic [DATA_W-1:0]                new_data,
    input  logic                             new_dirty,
    output logic [ENTRIES-1:0]               slot_valid,
    output logic [ENTRIES-1:0][ADDR_W-1:0]   slot_addr,
    output logic [ENTRIES-1:0][DATA_W-1:0]   slot_data,
    output logic [ENTRIES-1:0]               slot_dirty
);

    // Slot 0 is always the oldest block; valid slots stay packed from 0 upward.
    logic [ENTRIES-1:0]              s1_v, nx_v;
    logic [ENTRIES-1:0][ADDR_W-1:0]  s1_a, nx_a;
    logic [ENTRIES-1:0][DATA_W-1:0]  s1_d, nx_d;
    logic [ENTRIES-1:0]              s1_m, nx_m;
    logic [CNT_W-1:0]                occ, occ_after;

    always_comb begin
        occ = '0;
        for (int i = 0; i < ENTRIES; i++)
            occ = occ + CNT_W'(slot_valid[i]);
        occ_after = occ - CNT_W'(rm_en);
    end

    for (genvar i = 0; i < ENTRIES; i++) begin : g_slot
        logic close_gap;
        logic put_here;
        logic rolling;

        assign close_gap = rm_en && (IDX_W'(i) >= rm_idx);
        assign rolling   = (mode == FILL_ROLL);
        assign put_here  = ((mode == FILL_APPEND) && (occ_after == CNT_W'(i))) ||
                           (rolling && (i == ENTRIES - 1));

        if (i == ENTRIES - 1) begin : g_top
            // stage 1: the topmost slot empties when a gap closes below it
            assign s1_v[i] = close_gap ? 1'b0 : slot_valid[i];
            assign s1_a[i] = slot_addr[i];
            assign s1_d[i] = slot_data[i];
            assign s1_m[i] = slot_dirty[i];
            // stage 2: the newest block lands here on a roll
            assign nx_v[i] = put_here ? 1'b1      : s1_v[i];
            assign nx_a[i] = put_here ? new_addr  : s1_a[i];
            assign nx_d[i] = put_here ? new_data  : s1_d[i];
            assign nx_m[i] = put_here ? new_dirty : s1_m[i];
        end else begin : g_low
            assign s1_v[i] = close_gap ? slot_valid[i+1] : slot_valid[i];
            assign s1_a[i] = close_gap ? slot_addr[i+1]  : slot_addr[i];
            assign s1_d[i] = close_gap ? slot_data[i+1]  : slot_data[i];
            assign s1_m[i] = close_gap ? slot_dirty[i+1] : slot_dirty[i];
            assign nx_v[i] = put_here ? 1'b1      : (rolling ? s1_v[i+1] : s1_v[i]);
            assign nx_a[i] = put_here ? new_addr  : (rolling ? s1_a[i+1] : s1_a[i]);
            assign nx_d[i] = put_here ? new_data  : (rolling ? s1_d[i+1] : s1_d[i]);
            assign nx_m[i] = put_here ? new_dirty : (rolling ? s1_m[i+1] : s1_m[i]);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            slot_valid <= '0;
            slot_addr  <= '0;
            slot_data  <= '0;
            slot_dirty <= '0;
        end else begin
            slot_valid <= nx_v;
            slot_addr  <= nx_a;
            slot_data  <= nx_d;
            slot_dirty <= nx_m;
        end
    end

endmodule

// File: rtl/vbuf_resp.sv
module vbuf_resp #(
    parameter int unsigned ADDR_W = 26,
    parameter int unsigned DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              hit_any,
    input  logic [DATA_W-1:0] hit_data,
    input  logic              hit_dirty,
    input  logic              ev_fire,
    input  logic [ADDR_W-1:0] head_addr,
    input  logic [DATA_W-1:0] head_data,
    output logic              rsp_hit,
    output logic [DATA_W-1:0] rsp_data,
    output logic              rsp_dirty,
    output logic              ev_valid,
    output logic [ADDR_W-1:0] ev_addr,
    output logic [DATA_W-1:0] ev_data
);

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_hit   <= 1'b0;
            rsp_data  <= '0;
            rsp_dirty <= 1'b0;
            ev_valid  <= 1'b0;
            ev_addr   <= '0;
            ev_data   <= '0;
        end else begin
            rsp_hit   <= hit_any;
            rsp_data  <= hit_data;
            rsp_dirty <= hit_dirty;
            ev_valid  <= ev_fire;
            ev_addr   <= head_addr;
            ev_data   <= head_data;
        end
    end

endmodule

// File: rtl/victim_buffer.sv
module victim_buffer
    import vbuf_pkg::*;
#(
    parameter int unsigned ENTRIES = VB_ENTRIES_DEF,
    parameter int unsigned ADDR_W  = VB_ADDR_W_DEF,
    parameter int unsigned DATA_W  = VB_DATA_W_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ins_valid,
    input  logic [ADDR_W-1:0] ins_addr,
    input  logic [DATA_W-1:0] ins_data,
    input  logic              ins_dirty,
    input  logic              prb_valid,
    input  logic [ADDR_W-1:0] prb_addr,
    output logic              rsp_hit,
    output logic [DATA_W-1:0] rsp_data,
    output logic              rsp_dirty,
    output logic              ev_valid,
    output logic [ADDR_W-1:0] ev_addr,
    output logic [DATA_W-1:0] ev_data
);

    localparam int unsigned IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
    localparam int unsigned CNT_W = $clog2(ENTRIES + 1);

    logic [ENTRIES-1:0]              slot_valid;
    logic [ENTRIES-1:0][ADDR_W-1:0]  slot_addr;
    logic [ENTRIES-1:0][DATA_W-1:0]  slot_data;
    logic [ENTRIES-1:0]              slot_dirty;

    logic [ENTRIES-1:0] hit_vec;
    logic               hit_any;
    logic [IDX_W-1:0]   hit_idx;
    logic [DATA_W-1:0]  hit_data;
    logic               hit_dirty;

    logic       room;
    fill_mode_e mode;
    logic       ev_fire;

    vbuf_match #(
        .ENTRIES(ENTRIES), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W)
    ) u_match (
        .prb_valid (prb_valid),
        .prb_addr  (prb_addr),
        .slot_valid(slot_valid),
        .slot_addr (slot_addr),
        .slot_data (slot_data),
        .slot_dirty(slot_dirty),
        .hit_vec   (hit_vec),
        .hit_any   (hit_any),
        .hit_idx   (hit_idx),
        .hit_data  (hit_data),
        .hit_dirty (hit_dirty)
    );

    // A hit frees a slot this cycle, so a full buffer still has room then.
    assign room    = ~(&slot_valid) | hit_any;
    assign mode    = pick_fill(ins_valid, room);
    assign ev_fire = (mode == FILL_ROLL) & slot_dirty[0];

    vbuf_store #(
        .ENTRIES(ENTRIES), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
        .IDX_W(IDX_W), .CNT_W(CNT_W)
    ) u_store (
        .clk       (clk),
        .rst       (rst),
        .rm_en     (hit_any),
        .rm_idx    (hit_idx),
        .mode      (mode),
        .new_addr  (ins_addr),
        .new_data  (ins_data),
        .new_dirty (ins_dirty),
        .slot_valid(slot_valid),
        .slot_addr (slot_addr),
        .slot_data (slot_data),
        .slot_dirty(slot_dirty)
    );

    vbuf_resp #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W)
    ) u_resp (
        .clk      (clk),
        .rst      (rst),
        .hit_any  (hit_any),
        .hit_data (hit_data),
        .hit_dirty(hit_dirty),
        .ev_fire  (ev_fire),
        .head_addr(slot_addr[0]),
        .head_data(slot_data[0]),
        .rsp_hit  (rsp_hit),
        .rsp_data (rsp_data),
        .rsp_dirty(rsp_dirty),
        .ev_valid (ev_valid),
        .ev_addr  (ev_addr),
        .ev_data  (ev_data)
    );

endmodule

// File: rtl/vbuf_check.sv
module vbuf_check #(
    parameter int unsigned ENTRIES = 8
) (
    input logic               clk,
    input logic               rst,
    input logic               ins_valid,
    input logic               prb_valid,
    input logic               rsp_hit,
    input logic               ev_valid,
    input logic [ENTRIES-1:0] hit_vec,
    input logic [ENTRIES-1:0] slot_valid,
    input logic [ENTRIES-1:0] slot_dirty
);

    assert_match_onehot_R9: assert property (@(posedge clk) disable iff (rst)
        $onehot0(hit_vec));

    assert_rsp_follows_probe_R2: assert property (@(posedge clk) disable iff (rst)
        rsp_hit |-> $past(prb_valid));

    assert_evict_only_full_R5: assert property (@(posedge clk) disable iff (rst)
        ev_valid |-> ($past(ins_valid) && $past(&slot_valid) &&
                      !$past(|hit_vec) && $past(slot_dirty[0])));

    assert_packed_slots_R8: assert property (@(posedge clk) disable iff (rst)
        ((slot_valid & (slot_valid + 1'b1)) == '0));

    assert_occupancy_R4: assert property (@(posedge clk) disable iff (rst)
        $countones(slot_valid) ==
            ($past(ins_valid && (&slot_valid) && !(|hit_vec)) ? int'(ENTRIES) :
             $past($countones(slot_valid)) + int'($past(ins_valid)) - int'($past(|hit_vec))));

endmodule

bind victim_buffer vbuf_check #(.ENTRIES(ENTRIES)) u_vbuf_check (
    .clk       (clk),
    .rst       (rst),
    .ins_valid (ins_valid),
    .prb_valid (prb_valid),
    .rsp_hit   (rsp_hit),
    .ev_valid  (ev_valid),
    .hit_vec   (hit_vec),
    .slot_valid(slot_valid),
    .slot_dirty(slot_dirty)
);

// File: tb/tb_victim_buffer.sv
`timescale 1ns/1ps
module tb_victim_buffer;

    localparam int N  = 4;
    localparam int AW = 8;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst;
    logic          ins_valid, ins_dirty, prb_valid;
    logic [AW-1:0] ins_addr, prb_addr;
    logic [DW-1:0] ins_data;
    logic          rsp_hit, rsp_dirty, ev_valid;
    logic [DW-1:0] rsp_data, ev_data;
    logic [AW-1:0] ev_addr;

    victim_buffer #(.ENTRIES(N), .ADDR_W(AW), .DATA_W(DW)) dut (
        .clk(clk), .rst(rst),
        .ins_valid(ins_valid), .ins_addr(ins_addr), .ins_data(ins_data), .ins_dirty(ins_dirty),
        .prb_valid(prb_valid), .prb_addr(prb_addr),
        .rsp_hit(rsp_hit), .rsp_data(rsp_data), .rsp_dirty(rsp_dirty),
        .ev_valid(ev_valid), .ev_addr(ev_addr), .ev_data(ev_data)
    );

    always #10 clk = ~clk;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    // Queue model: index 0 is the oldest block
    logic [AW-1:0] q_addr [N];
    logic          q_dirty[N];
    int            q_cnt = 0;

    function automatic logic [DW-1:0] pat(input logic [AW-1:0] a);
        return {a, a ^ 8'hA5};
    endfunction

    function automatic int find(input logic [AW-1:0] a);
        for (int i = 0; i < q_cnt; i++)
            if (q_addr[i] == a) return i;
        return -1;
    endfunction

    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // One cycle: optional insert and optional probe, then compare responses
    task automatic op(input string tag, input bit iv, input logic [AW-1:0] ia, input bit id,
                      input bit pv, input logic [AW-1:0] pa);
        int            idx;
        bit            e_hit = 1'b0;
        bit            e_dirty = 1'b0;
        bit            e_ev = 1'b0;
        logic [AW-1:0] e_ev_addr = '0;
        if (pv) begin
            idx = find(pa);
            if (idx >= 0) begin
                e_hit   = 1'b1;
                e_dirty = q_dirty[idx];
                for (int j = idx; j < q_cnt - 1; j++) begin
                    q_addr[j]  = q_addr[j+1];
                    q_dirty[j] = q_dirty[j+1];
                end
                q_cnt--;
            end
        end
        if (iv) begin
            if (q_cnt < N) begin
                q_addr[q_cnt]  = ia;
                q_dirty[q_cnt] = id;
                q_cnt++;
            end else begin
                e_ev      = q_dirty[0];
                e_ev_addr = q_addr[0];
                for (int j = 0; j < N - 1; j++) begin
                    q_addr[j]  = q_addr[j+1];
                    q_dirty[j] = q_dirty[j+1];
                end
                q_addr[N-1]  = ia;
                q_dirty[N-1] = id;
            end
        end
        ins_valid = iv; ins_addr = ia; ins_data = pat(ia); ins_dirty = id;
        prb_valid = pv; prb_addr = pa;
        @(negedge clk);
        ins_valid = 1'b0;
        prb_valid = 1'b0;
        check(tag, "rsp_hit", 32'(rsp_hit), 32'(e_hit));
        if (e_hit) begin
            check(tag, "rsp_data", 32'(rsp_data), 32'(pat(pa)));
            check(tag, "rsp_dirty", 32'(rsp_dirty), 32'(e_dirty));
        end
        check(tag, "ev_valid", 32'(ev_valid), 32'(e_ev));
        if (e_ev) begin
            check(tag, "ev_addr", 32'(ev_addr), 32'(e_ev_addr));
            check(tag, "ev_data", 32'(ev_data), 32'(pat(e_ev_addr)));
        end
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        ins_valid = 1'b0; ins_addr = '0; ins_data = '0; ins_dirty = 1'b0;
        prb_valid = 1'b0; prb_addr = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state, then every address misses
        check("R1", "rsp_hit after reset", 32'(rsp_hit), 32'd0);
        check("R1", "ev_valid after reset", 32'(ev_valid), 32'd0);
        for (int a = 0; a < 256; a++)
            op("R1", 1'b0, '0, 1'b0, 1'b1, AW'(a));

        // R4: fill without eviction
        op("R4", 1'b1, 8'h10, 1'b1, 1'b0, '0);
        op("R4", 1'b1, 8'h11, 1'b0, 1'b0, '0);
        op("R4", 1'b1, 8'h12, 1'b1, 1'b0, '0);
        op("R4", 1'b1, 8'h13, 1'b0, 1'b0, '0);
        // R2 hit with data and flag, R3 removal, R2 miss
        op("R2", 1'b0, '0, 1'b0, 1'b1, 8'h12);
        op("R3", 1'b0, '0, 1'b0, 1'b1, 8'h12);
        op("R2", 1'b0, '0, 1'b0, 1'b1, 8'h99);

        // R5 / R6: rollover with modified and clean heads
        op("R4", 1'b1, 8'h20, 1'b1, 1'b0, '0);
        op("R5", 1'b1, 8'h21, 1'b0, 1'b0, '0);
        op("R6", 1'b1, 8'h22, 1'b1, 1'b0, '0);
        op("R6", 1'b0, '0, 1'b0, 1'b1, 8'h11);

        // R8: remove from the middle, then displacement skips it
        op("R8", 1'b0, '0, 1'b0, 1'b1, 8'h20);
        op("R8", 1'b1, 8'h23, 1'b0, 1'b0, '0);
        op("R8", 1'b1, 8'h24, 1'b1, 1'b0, '0);
        op("R8", 1'b1, 8'h25, 1'b1, 1'b0, '0);
        op("R8", 1'b1, 8'h26, 1'b0, 1'b0, '0);

        // R7: same-cycle probe of the inserted address misses, insert lands
        op("R7", 1'b1, 8'h30, 1'b1, 1'b1, 8'h30);
        op("R7", 1'b0, '0, 1'b0, 1'b1, 8'h30);
        op("R7", 1'b1, 8'h31, 1'b1, 1'b0, '0);
        // R7: full buffer, probe hit plus insert, modified head stays
        op("R7", 1'b1, 8'h40, 1'b1, 1'b1, 8'h25);
        op("R5", 1'b1, 8'h41, 1'b0, 1'b0, '0);

        // R9 sweep over a small address space
        for (int k = 0; k < 3000; k++) begin
            logic [AW-1:0] pa;
            logic [AW-1:0] ia;
            bit            iv;
            bit            pv;
            pa = AW'((k * 7 + 3) % 32);
            ia = AW'((k * 11 + 5) % 32);
            pv = (k % 2) == 0 || (k % 5) == 1;
            iv = (find(ia) < 0) && ((k % 3) != 0);
            op("R9", iv, ia, bit'((k / 3) % 2), pv, pa);
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule